// File: doc/BRIEF.md
# LED Sink Driver Serial Core with Fault Readback

This block is the digital part of an eight-channel constant-current LED sink driver. A host streams display bits into a serial-in, parallel-out shift register, one bit per qualified rising clock edge. It then copies the word into a storage register with a latch-enable input. An active-low output enable gates the stored bits onto eight channel-on lines. The last stage of the shift register leaves the block on a serial output, so that several drivers can be chained. That serial output is updated on the falling clock edge. The next device in the chain therefore always sees stable data at its own rising edge.

A detection mode lets the host read per-channel fault status through the same serial path. The host loads and latches all ones and pulls the output enable low for the test window. When the enable returns high, the eight fault flags from the analog comparators are loaded in parallel into the shift register. The host then clocks them out on the serial output in the same bit order as display data. The current sources and comparators are outside this block and appear only as the `fault` input vector.

Top module: `led_sink_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the shift register and storage register clear to 0. `sdo` clears to 0 at the falling edge, and every `ch_on` bit is 0.
- R2: At a rising edge with `shift_en` high and no capture, bit 0 takes `sdi` and bit i takes the former bit i-1. With `shift_en` low and no capture, the shift register holds.
- R3: `sdo` takes the shift register's bit 7 at each falling edge and keeps its value across the rising edge. A new value therefore appears half a cycle after the shift.
- R4: At a rising edge with `latch_en` high, the storage register takes the value the shift register holds after that same edge. With `latch_en` low, it holds.
- R5: `ch_on[i]` is 1 exactly when `oe_n` is 0 and storage bit i is 1.
- R6: With `det_mode` high, a rising edge that samples `oe_n` high after it was sampled low on the previous edge loads `fault` into the shift register, with bit i taken from `fault[i]`. This load takes priority over shifting.
- R7: After a capture, `sdo` presents `fault[7]` at the next falling edge. Each further shift presents the next lower flag, down to `fault[0]`.
- R8: With `det_mode` low, a rising `oe_n` has no effect on the shift register, whatever `fault` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; shifts on rising edges, serial output moves on falling edges |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial data in |
| shift_en | input | 1 | Qualifies a shift at the rising edge |
| latch_en | input | 1 | Copies the shift register into the storage register |
| oe_n | input | 1 | Active-low output enable; its rising edge ends a detection window |
| det_mode | input | 1 | Selects detection mode |
| fault | input | 8 | Per-channel fault flags from the analog comparators |
| sdo | output | 1 | Serial data out for cascading and fault readback |
| ch_on | output | 8 | Channel drive enables |

## Verification
The bench sweeps all 256 display words through shift, latch and gating. It also sweeps all 256 fault vectors through capture and readback, so that any swapped, stuck or reversed bit shows up as a wrong channel or a wrong serial bit. Just after each rising edge it samples `sdo` to confirm the old bit is still there. A serial output moved to the rising edge would give the next device a bit half a cycle early. It also checks that the stored word survives a shift made with the latch closed, which catches a storage register that follows the shift register. Finally, it pulses the enable outside detection mode with faults present. A design that captured there would destroy the queued display data.

// File: rtl/led_sink_pkg.sv
// Package: shared constants for the LED sink core.
// Assumes: a channel count no larger than the shift width a host can stream.
package led_sink_pkg;
    parameter int unsigned LSD_CHANNELS = 8;
endpackage

// File: rtl/lsd_oe_edge.sv
// Module: lsd_oe_edge
// Detects the end of a detection window: oe_n seen high after it was seen
// low at the previous rising edge, while detection mode is selected.
// Assumes: oe_n and det_mode are synchronous to clk.
module lsd_oe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic det_mode,
    output logic capture
);
    logic oe_low_q;

    // Remember whether the enable was asserted at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_low_q <= 1'b0;
        else        oe_low_q <= ~oe_n;
    end

    // Capture request on the release of the enable in detection mode.
    always_comb capture = det_mode & oe_n & oe_low_q;

    AST_CAPTURE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> ($past(oe_n) == 1'b0)); // R6
endmodule

// File: rtl/lsd_shift.sv
// Module: lsd_shift
// Serial-in, parallel-out shift register with parallel fault load and a
// falling-edge serial output register.
// Assumes: load has priority over shift; sdi enters bit 0.
module lsd_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next,
    output logic         sdo
);
    localparam int unsigned MSB = W - 1;

    // Next-state selection: parallel load, shift, or hold.
    always_comb begin
        if (load)          q_next = load_val;
        else if (shift_en) q_next = {q[MSB-1:0], sdi};
        else               q_next = q;
    end

    // Shift register state.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // Serial output moves on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) sdo <= 1'b0;
        else        sdo <= q[MSB];
    end

    AST_SHIFT_RESET: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(q)); // R2
    AST_SHIFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val))); // R6
    AST_SDO_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sdo == q[MSB])); // R3
endmodule

// File: rtl/lsd_store.sv
// Module: lsd_store
// Storage register; follows its input at every edge with le high, holds
// otherwise.
// Assumes: d is the shift register's next state, so a latch on the last
// shift captures the complete word.
module lsd_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Storage update under latch enable.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (le) q <= d;
    end

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(q)); // R4
endmodule

// File: rtl/led_sink_core.sv
// Module: led_sink_core
// Digital core of an LED sink driver: serial load, storage latch, gated
// channel enables and fault readback over the serial chain.
// Assumes: all inputs synchronous to clk; fault valid at the enable release.
module led_sink_core #(
    parameter int unsigned CH = led_sink_pkg::LSD_CHANNELS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdi,
    input  logic          shift_en,
    input  logic          latch_en,
    input  logic          oe_n,
    input  logic          det_mode,
    input  logic [CH-1:0] fault,
    output logic          sdo,
    output logic [CH-1:0] ch_on
);
    logic          capture;
    logic [CH-1:0] sr_q;
    logic [CH-1:0] sr_next;
    logic [CH-1:0] store_q;

    lsd_oe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .det_mode (det_mode),
        .capture  (capture)
    );

    lsd_shift #(.W(CH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdi      (sdi),
        .load     (capture),
        .load_val (fault),
        .q        (sr_q),
        .q_next   (sr_next),
        .sdo      (sdo)
    );

    lsd_store #(.W(CH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (latch_en),
        .d     (sr_next),
        .q     (store_q)
    );

    // Channel gating by the active-low enable.
    always_comb ch_on = store_q & {CH{~oe_n}};

    AST_CH_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_on & ~store_q) == '0)); // R5
    AST_CH_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (ch_on == '0)); // R5
    AST_NORMAL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_mode && !shift_en) |=> $stable(sr_q)); // R8
endmodule

// File: tb/led_sink_core_tb.sv
module led_sink_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdi = 1'b0;
    logic       shift_en = 1'b0;
    logic       latch_en = 1'b0;
    logic       oe_n = 1'b1;
    logic       det_mode = 1'b0;
    logic [7:0] fault = 8'h00;
    logic       sdo;
    logic [7:0] ch_on;

    int checks = 0;
    int failures = 0;
    logic [7:0] sr_model = 8'h00;

    always #2 clk = ~clk;

    led_sink_core u_dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_en(shift_en),
        .latch_en(latch_en), .oe_n(oe_n), .det_mode(det_mode),
        .fault(fault), .sdo(sdo), .ch_on(ch_on)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic to_pos();
        @(posedge clk); #1;
    endtask

    task automatic to_neg();
        @(negedge clk); #1;
    endtask

    // Shift one byte MSB first; optionally latch on the last bit.
    task automatic shift_byte(input logic [7:0] p, input bit do_latch);
        for (int i = 7; i >= 0; i--) begin
            sdi = p[i];
            shift_en = 1'b1;
            latch_en = do_latch && (i == 0);
            to_pos();
            check("R3 sdo holds across rising edge", {7'b0, sdo}, {7'b0, sr_model[7]});
            sr_model = {sr_model[6:0], p[i]};
            to_neg();
            check("R2 shift order seen on sdo", {7'b0, sdo}, {7'b0, sr_model[7]});
        end
        shift_en = 1'b0;
        latch_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) to_neg();
        check("R1 reset ch_on", ch_on, 8'h00);
        check("R1 reset sdo", {7'b0, sdo}, 8'h00);
        oe_n = 1'b0;
        #1;
        check("R1 reset storage empty", ch_on, 8'h00);
        oe_n = 1'b1;
        rst_n = 1'b1;
        to_neg();

        // R2 R4 R5: all display words.
        for (int p = 0; p < 256; p++) begin
            shift_byte(p[7:0], 1'b1);
            check("R5 disabled outputs off", ch_on, 8'h00);
            oe_n = 1'b0;
            to_pos();
            check("R4 R5 latched word drives channels", ch_on, p[7:0]);
            to_pos();
            oe_n = 1'b1;
            #1;
            check("R5 release turns channels off", ch_on, 8'h00);
            to_neg();
        end

        // R4: shifting with latch closed keeps the stored word.
        shift_byte(8'h96, 1'b1);
        shift_byte(8'h5A, 1'b0);
        oe_n = 1'b0;
        to_pos();
        check("R4 storage holds without latch", ch_on, 8'h96);
        oe_n = 1'b1;
        to_neg();

        // R2: no shift_en keeps the register.
        sdi = 1'b1;
        repeat (4) to_pos();
        to_neg();
        check("R2 hold without shift_en", {7'b0, sdo}, {7'b0, sr_model[7]});

        // R8: normal-mode enable pulse with faults present.
        shift_byte(8'h3C, 1'b0);
        fault = 8'hC3;
        oe_n = 1'b0;
        repeat (2) to_pos();
        oe_n = 1'b1;
        repeat (2) to_pos();
        to_neg();
        check("R8 no capture in normal mode", {7'b0, sdo}, {7'b0, sr_model[7]});
        shift_byte(8'h00, 1'b0);
        fault = 8'h00;

        // R6 R7: detection readback of all fault vectors.
        det_mode = 1'b1;
        for (int f = 0; f < 256; f++) begin
            shift_byte(8'hFF, 1'b1);
            oe_n = 1'b0;
            to_pos();
            check("R5 detection drives all channels", ch_on, 8'hFF);
            repeat (2) to_pos();
            fault = f[7:0];
            oe_n = 1'b1;
            to_pos();
            check("R3 sdo unchanged at capture edge", {7'b0, sdo}, 8'h01);
            sr_model = f[7:0];
            to_neg();
            check("R7 first readback bit is fault[7]", {7'b0, sdo}, {7'b0, f[7]});
            fault = 8'h00;
            for (int j = 6; j >= 0; j--) begin
                sdi = 1'b0;
                shift_en = 1'b1;
                to_pos();
                sr_model = {sr_model[6:0], 1'b0};
                to_neg();
                check("R6 R7 readback bit order", {7'b0, sdo}, {7'b0, f[j]});
            end
            shift_en = 1'b0;
            sr_model = {sr_model[6:0], 1'b0};
            sdi = 1'b0;
            shift_en = 1'b1;
            to_pos();
            shift_en = 1'b0;
            to_neg();
        end
        det_mode = 1'b0;

        // R1: reset in mid-operation.
        shift_byte(8'hA5, 1'b1);
        rst_n = 1'b0;
        to_neg();
        to_neg();
        oe_n = 1'b0;
        #1;
        check("R1 reset clears storage", ch_on, 8'h00);
        check("R1 reset clears sdo", {7'b0, sdo}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule